// File: doc/BRIEF.md
# Platform Environment Control Interface Host Register Stub

This block stands in for the host-side register set of a processor thermal and power management controller. No serial wire is driven. A command that the block accepts completes on the same clock edge and returns a fixed success code. Firmware sees the same register behaviour and interrupt flow that real hardware gives, so it can be run without a client device attached.

Access uses a simple 32-bit register bus: separate read and write strobes, a byte address, write data and combinational read data. There is one level interrupt output. The register window holds a fixed number of 32-bit words. Five words have special behaviour:

- the command word
- the interrupt enable word
- the interrupt status word
- the first transmit buffer word
- the first receive buffer word

Every other word in the window is plain storage. A one-cycle error pulse marks a refused command and any access outside the window.

Top module: `peci_regstub`

## Requirements
- R1: After a synchronous active-low reset, every word in the window reads 0 and both `irq` and `err` are 0.
- R2: A write to an in-range offset that is not 0x08 or 0x1C stores all 32 bits. A later read at that offset returns the stored word on `bus_rdata` in the same cycle as the read strobe.
- R3: The command word at offset 0x08 always reads 0. A write there with bit 0 clear changes no register, no output and no buffer.
- R4: A fire is a write to 0x08 with bit 0 set. If the status word is 0 when the fire arrives, it is accepted and sets the word at 0x20 and the word at 0x30 to 0x00000040.
- R5: On an accepted fire, the status word at 0x1C is replaced by bit 0 of the enable word at 0x18, placed in bit 0. All other status bits become 0, whatever the enable word holds.
- R6: `irq` is a registered level that goes high on the edge of an accepted fire only when enable bit 0 is set. It stays low when that bit is clear.
- R7: A fire that arrives while the status word is nonzero is refused. The buffers and the status word are unchanged, and `err` is 1 for the following cycle.
- R8: A write to 0x1C clears each status bit written as 1 and leaves bits written as 0. `irq` falls on that same edge once the status becomes 0.
- R9: An access at byte offset 0x40 or above reads 0 and its write is dropped. In particular, it does not alias onto a low word. `err` is 1 for the following cycle.
- R10: `err` is 1 only in the single cycle after a refused fire or an out-of-range access, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one access per asserted cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq | output | 1 | Level interrupt, high while status is nonzero |
| err | output | 1 | One-cycle pulse for a refused fire or an out-of-range access |

## Verification
The fire is tried with the enable bit clear, with the enable bit set alongside unrelated enable bits, and again while status is still pending. These three cases separate masking from plain copying of the enable word, and acceptance from refusal.

Status clears are tried with a mask that misses the pending bit and then with one that hits it. This shows that clearing is per bit rather than triggered by any write.

A command write with bit 0 clear and an out-of-range write whose low address bits point at a stored word check that neither reaches storage. A reference model compares `irq` and `err` on every cycle.

// File: rtl/peci_stub_pkg.sv
// Package: shared word indices and constants for the register stub.
// Assumes 32-bit words on a byte-addressed bus; indices are word numbers.
package peci_stub_pkg;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned CMD_IDX   = 2;   // byte 0x08
    localparam int unsigned CTRL_IDX  = 6;   // byte 0x18
    localparam int unsigned STS_IDX   = 7;   // byte 0x1C
    localparam int unsigned TXD_IDX   = 8;   // byte 0x20
    localparam int unsigned RXD_IDX   = 12;  // byte 0x30
    localparam logic [DATA_W-1:0] DONE_CODE = 32'h0000_0040;
endpackage

// File: rtl/peci_addr_decode.sv
// Module: peci_addr_decode
// Turns the byte address and strobes into range and target qualifiers.
// Assumes word-aligned accesses; the two low address bits are ignored.
module peci_addr_decode #(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned NUM_WORDS = 16,
    localparam int unsigned IDX_W    = $clog2(NUM_WORDS)
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic              in_range,
    output logic [IDX_W-1:0]  word_idx,
    output logic              cmd_wr,
    output logic              sts_wr,
    output logic              plain_wr,
    output logic              oob_access
);
    import peci_stub_pkg::*;

    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(NUM_WORDS * 4);

    // Range check and word index extraction.
    always_comb begin
        in_range = (bus_addr < LIMIT);
        word_idx = bus_addr[IDX_W+1:2];
    end

    // Classify a write by its target word.
    always_comb begin
        cmd_wr     = bus_wr && in_range && (word_idx == IDX_W'(CMD_IDX));
        sts_wr     = bus_wr && in_range && (word_idx == IDX_W'(STS_IDX));
        plain_wr   = bus_wr && in_range && !cmd_wr && !sts_wr;
        oob_access = (bus_wr || bus_rd) && !in_range;
    end
endmodule

// File: rtl/peci_cmd_ctrl.sv
// Module: peci_cmd_ctrl
// Owns the status word and the interrupt level; decides fire acceptance.
// Assumes status is only changed by an accepted fire or a clear write.
module peci_cmd_ctrl #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic              sts_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              done_en,
    output logic [DATA_W-1:0] status,
    output logic              fire_ok,
    output logic              fire_refused,
    output logic              irq
);
    logic              fire_req;
    logic [DATA_W-1:0] status_nx;

    // Acceptance: a fire is taken only while nothing is pending.
    always_comb begin
        fire_req     = cmd_wr && wdata[0];
        fire_refused = fire_req && (status != '0);
        fire_ok      = fire_req && (status == '0);
    end

    // Next status: masked done on accept, bitwise clear on a status write.
    always_comb begin
        status_nx = status;
        if (fire_ok)
            status_nx = {{(DATA_W-1){1'b0}}, done_en};
        else if (sts_wr)
            status_nx = status & ~wdata;
    end

    // Status and interrupt registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
            irq    <= 1'b0;
        end else begin
            status <= status_nx;
            irq    <= (status_nx != '0);
        end
    end

    assert_fire_raises_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_ok && done_en) |=> irq);
    assert_fire_masked_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_ok && !done_en) |=> !irq);
    assert_refused_keeps_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fire_refused |=> $stable(status));
    assert_full_clear_drops_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr && !fire_ok && ((status & ~wdata) == '0)) |=> !irq);
    assert_masked_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fire_ok |=> (status == {{(DATA_W-1){1'b0}}, $past(done_en)}));
endmodule

// File: rtl/peci_reg_file.sv
// Module: peci_reg_file
// Word storage with read mux; command word is unstored, status comes from outside.
// Assumes at most one access target per cycle.
module peci_reg_file #(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned NUM_WORDS = 16,
    localparam int unsigned IDX_W    = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              plain_wr,
    input  logic              in_range,
    input  logic [IDX_W-1:0]  word_idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              fire_ok,
    input  logic [DATA_W-1:0] status,
    output logic [DATA_W-1:0] rdata,
    output logic              done_en
);
    import peci_stub_pkg::*;

    logic [NUM_WORDS-1:0][DATA_W-1:0] words;

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        if (i == CMD_IDX || i == STS_IDX) begin : g_none
            // Not stored here: command reads zero, status lives in the controller.
            assign words[i] = '0;
        end else begin : g_store
            logic [DATA_W-1:0] q;
            localparam bit IS_BUF = (i == TXD_IDX) || (i == RXD_IDX);
            // Word register: completion code on accept, else plain write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else if (IS_BUF && fire_ok)
                    q <= DONE_CODE;
                else if (plain_wr && word_idx == IDX_W'(i))
                    q <= wdata;
            end
            assign words[i] = q;
        end
    end

    // Read mux with the out-of-range and status cases.
    always_comb begin
        if (!in_range)
            rdata = '0;
        else if (word_idx == IDX_W'(STS_IDX))
            rdata = status;
        else
            rdata = words[word_idx];
    end

    // Enable bit for the done event.
    assign done_en = words[CTRL_IDX][0];

    assert_buffers_loaded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fire_ok |=> (words[TXD_IDX] == DONE_CODE && words[RXD_IDX] == DONE_CODE));
    assert_cmd_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_range && word_idx == IDX_W'(CMD_IDX)) |-> (rdata == '0));
endmodule

// File: rtl/peci_regstub.sv
// Module: peci_regstub (top)
// Host register stub: decode, storage, command control and the error pulse.
// Assumes a single-master bus with at most one access per cycle.
module peci_regstub #(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned NUM_WORDS = 16,
    localparam int unsigned DATA_W   = peci_stub_pkg::DATA_W,
    localparam int unsigned IDX_W    = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              err
);
    logic              in_range;
    logic [IDX_W-1:0]  word_idx;
    logic              cmd_wr;
    logic              sts_wr;
    logic              plain_wr;
    logic              oob_access;
    logic              done_en;
    logic              fire_ok;
    logic              fire_refused;
    logic [DATA_W-1:0] status;

    peci_addr_decode #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)) u_dec (
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .in_range  (in_range),
        .word_idx  (word_idx),
        .cmd_wr    (cmd_wr),
        .sts_wr    (sts_wr),
        .plain_wr  (plain_wr),
        .oob_access(oob_access)
    );

    peci_cmd_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_wr      (cmd_wr),
        .sts_wr      (sts_wr),
        .wdata       (bus_wdata),
        .done_en     (done_en),
        .status      (status),
        .fire_ok     (fire_ok),
        .fire_refused(fire_refused),
        .irq         (irq)
    );

    peci_reg_file #(.DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .plain_wr(plain_wr),
        .in_range(in_range),
        .word_idx(word_idx),
        .wdata   (bus_wdata),
        .fire_ok (fire_ok),
        .status  (status),
        .rdata   (bus_rdata),
        .done_en (done_en)
    );

    // Error pulse: one cycle after a refused fire or an out-of-range access.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err <= 1'b0;
        else
            err <= oob_access || fire_refused;
    end

    assert_oob_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        oob_access |=> err);
    assert_oob_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !in_range) |-> (bus_rdata == '0));
    assert_err_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!oob_access && !fire_refused) |=> !err);
endmodule

// File: tb/peci_regstub_test.sv
`timescale 1ns/1ps
module peci_regstub_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        err;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    // Reference model state.
    logic [31:0] m_mem [16];
    logic [31:0] m_sts;
    logic        m_irq;
    logic        m_err;

    always #2.5 clk = ~clk;

    peci_regstub uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .err(err)
    );

    function automatic logic [31:0] model_read(input logic [11:0] a);
        int idx;
        if (a >= 12'h040) return 32'h0;
        idx = int'(a[5:2]);
        if (idx == 2) return 32'h0;
        if (idx == 7) return m_sts;
        return m_mem[idx];
    endfunction

    // Behavioural model step on every clock edge.
    always @(posedge clk) begin
        int idx;
        cycles++;
        if (!rst_n) begin
            foreach (m_mem[k]) m_mem[k] = '0;
            m_sts = '0; m_irq = 1'b0; m_err = 1'b0;
        end else begin
            m_err = 1'b0;
            idx = int'(bus_addr[5:2]);
            if ((bus_wr || bus_rd) && bus_addr >= 12'h040) begin
                m_err = 1'b1;
            end else if (bus_wr) begin
                if (idx == 2) begin
                    if (bus_wdata[0]) begin
                        if (m_sts != 0) m_err = 1'b1;
                        else begin
                            m_mem[8] = 32'h40; m_mem[12] = 32'h40;
                            m_sts = {31'b0, m_mem[6][0]};
                        end
                    end
                end else if (idx == 7) begin
                    m_sts = m_sts & ~bus_wdata;
                end else begin
                    m_mem[idx] = bus_wdata;
                end
            end
            m_irq = (m_sts != 0);
        end
    end

    // Per-cycle comparison of the level outputs, away from the edge.
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (irq !== m_irq) begin
                failures++;
                $display("FAIL R6/R8 irq actual=%0b expected=%0b t=%0t", irq, m_irq, $time);
            end
            checks++;
            if (err !== m_err) begin
                failures++;
                $display("FAIL R10 err actual=%0b expected=%0b t=%0t", err, m_err, $time);
            end
        end
    end

    always @(posedge clk) begin
        if (cycles > 20000) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input string req);
        logic [31:0] exp;
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        exp = model_read(a);
        checks++;
        if (bus_rdata !== exp) begin
            failures++;
            $display("FAIL %s addr=%h actual=%h expected=%h", req, a, bus_rdata, exp);
        end
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    // Direct check of an absolute expected word (independent of the model).
    task automatic rd_abs(input logic [11:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        checks++;
        if (bus_rdata !== exp) begin
            failures++;
            $display("FAIL %s addr=%h actual=%h expected=%h", req, a, bus_rdata, exp);
        end
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        for (int a = 0; a < 64; a += 4) rd_abs(12'(a), 32'h0, "R1");
        // R2: plain storage
        wr(12'h004, 32'hA5A5_1234);
        wr(12'h03C, 32'hFFFF_0000);
        wr(12'h010, 32'h0BAD_F00D);
        rd_abs(12'h004, 32'hA5A5_1234, "R2");
        rd_abs(12'h03C, 32'hFFFF_0000, "R2");
        rd(12'h010, "R2");
        // R3: command with bit 0 clear does nothing
        wr(12'h008, 32'hFFFF_FFFE);
        rd_abs(12'h008, 32'h0, "R3");
        rd_abs(12'h020, 32'h0, "R3");
        rd_abs(12'h01C, 32'h0, "R3");
        // R4/R5/R6: fire with enable bit 0 clear
        wr(12'h020, 32'h1111_1111);
        wr(12'h030, 32'h2222_2222);
        wr(12'h018, 32'hFFFF_FFFE);
        wr(12'h008, 32'h0000_0001);
        rd_abs(12'h020, 32'h40, "R4");
        rd_abs(12'h030, 32'h40, "R4");
        rd_abs(12'h01C, 32'h0, "R5");
        rd_abs(12'h008, 32'h0, "R3");
        // R5/R6: fire with enable set plus unrelated bits
        wr(12'h030, 32'h3333_3333);
        wr(12'h018, 32'h0000_0003);
        wr(12'h008, 32'hFFFF_FFFF);
        rd_abs(12'h01C, 32'h1, "R5");
        rd_abs(12'h030, 32'h40, "R4");
        @(negedge clk);
        checks++;
        if (irq !== 1'b1) begin failures++; $display("FAIL R6 irq actual=%0b expected=1", irq); end
        // R7: refused fire while pending
        wr(12'h020, 32'h0000_0055);
        wr(12'h008, 32'h0000_0001);
        rd_abs(12'h020, 32'h55, "R7");
        rd_abs(12'h01C, 32'h1, "R7");
        // R8: clear with a mask missing the pending bit, then hitting it
        wr(12'h01C, 32'h0000_0002);
        rd_abs(12'h01C, 32'h1, "R8");
        wr(12'h01C, 32'h0000_0001);
        rd_abs(12'h01C, 32'h0, "R8");
        // fire accepted again after clear
        wr(12'h030, 32'h7);
        wr(12'h008, 32'h1);
        rd_abs(12'h030, 32'h40, "R4");
        wr(12'h01C, 32'hFFFF_FFFF);
        // R9: out-of-range accesses
        wr(12'h044, 32'hDEAD_BEEF);
        rd_abs(12'h004, 32'hA5A5_1234, "R9");
        rd_abs(12'h044, 32'h0, "R9");
        wr(12'hFFC, 32'h1234_5678);
        rd_abs(12'h03C, 32'hFFFF_0000, "R9");
        rd(12'h800, "R9");
        repeat (3) @(posedge clk);
        // R10: error stays low when idle (checked each cycle above)
        #1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule